// File: doc/BRIEF.md
# UART Autobaud Detector with Trim

This block works out the bit period of an asynchronous serial link from known characters arriving on the receive line, and hands that period to a separate UART receiver. After reset it sits in a coarse search. At every falling edge of the synchronised line it looks at two intervals: the time back to the previous falling edge, and the width of the high pulse between them. Only the pattern of the ASCII '>' character (0x3E, sent LSB first) has a falling-edge spacing of seven bits and a high run of five bits. When the two intervals fit that ratio, the block locks and derives the bit period from the falling-edge spacing.

The host sends a pad character straight after the '>'. The block does not try to interpret it; it only counts the pad's two falling edges. On the second of those edges it enables the receiver, while the line is still low, so that the receiver catches the next start bit cleanly.

From then on the block keeps refining the rate. A timer measures four full falling-to-falling periods, which is eight bits. Every byte strobe from the receiver restarts that timer, so only a 0x55 character can fit four periods between two strobes. When a capture completes, it replaces the bit period unless it is implausibly short. A relock request sends the block back to the coarse search.

Top module: `autobaud_trim`

## Requirements
- R1: After reset `locked_o` and `rx_en_o` are 0 and `bit_per_o` is 0.
- R2: In the coarse phase, a falling edge is a candidate. Let F be the clocks since the previous falling edge and H the clocks the line was high in between. The candidate is accepted only if H is nonzero, 245·H ≤ 180·F and 175·F ≤ 252·H. This is a 7:5 ratio with about 1/35 tolerance. 0x3E sent LSB first (start bit, then data bit 0 low, data bits 1–5 high, data bits 6–7 low, stop bit high) gives F = 7 bits and H = 5 bits. 0x55 and 0x20 are rejected.
- R3: A candidate with F or H above `COARSE_MAX` is rejected. Both counters saturate, so an edge after a long idle is never accepted.
- R4: On acceptance, `bit_per_o` becomes floor(F·65536/7) in unsigned 16.16 fixed point and `locked_o` goes to 1. The rest of the lock character is ignored.
- R5: After lock, the next two falling edges are consumed as the pad, whatever the pad character is. `rx_en_o` rises on the second of them, and `bit_per_o` does not change during the pad.
- R6: In the trim phase, the four-period timer is armed on entry and by every `byte_stb_i` pulse. The first falling edge after arming starts it. The fifth falling edge captures the elapsed clocks C and sets `bit_per_o` to C·8192, which is C/8 bits in 16.16. The timer then stays idle until it is armed again.
- R7: When the receiver strobes every byte, a byte other than 0x55 (for example 0xAA) leaves `bit_per_o` unchanged.
- R8: A capture with C below `TRIM_MIN` is discarded and leaves `bit_per_o` unchanged. A capture whose counter saturated is also discarded.
- R9: A `relock_i` pulse returns the block to the coarse phase and clears `locked_o` and `rx_en_o` on the next clock. `bit_per_o` keeps its value until the next lock.
- R10: `bit_per_o`, `locked_o` and `rx_en_o` change on the third rising clock edge after the `rx_i` transition that caused the change. This is two synchroniser stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| byte_stb_i | input | 1 | One-cycle pulse from the receiver for each byte received |
| relock_i | input | 1 | Request to restart the coarse search |
| bit_per_o | output | 32 | Clocks per bit, unsigned 16.16 |
| locked_o | output | 1 | Coarse lock obtained |
| rx_en_o | output | 1 | Receiver enable |

## Verification
Every result is due on the third rising edge after the line transition that causes it. The bench drives `rx_i` on falling clock edges and samples outputs on falling edges. It confirms `rx_en_o` still low two edges after the pad's second fall and high one edge later. Changes of `bit_per_o` are popped from a queue of expected values as soon as the monitor sees them, so any change nobody asked for is reported. Cases that must leave the period alone (rejected candidates, the pad, 0xAA, a short capture) are checked at the ports after the whole frame and its idle gap have passed.

// File: rtl/abd_pkg.sv
package abd_pkg;
  localparam int FRAC_W        = 16;
  localparam int BP_W          = 32;
  localparam int SIG_FALL_BITS = 7;
  localparam int SIG_HIGH_BITS = 5;
  localparam int TOL_NUM       = 36;
  localparam int TOL_DEN       = 35;
  localparam int PAD_FALLS     = 2;
  localparam int TRIM_PERIODS  = 4;
  localparam int TRIM_BITS     = 2 * TRIM_PERIODS;

  typedef logic [BP_W-1:0] bit_per_t;
  typedef enum logic [1:0] {PH_COARSE, PH_PAD, PH_TRIM} phase_e;
endpackage

// File: rtl/abd_line_sync.sv
module abd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic line_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-1:0], rx_i};
  end

  assign line_o = sh_q[STAGES-1];
  assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/abd_coarse_meas.sv
module abd_coarse_meas
  import abd_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int COARSE_MAX = 60000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             fall_i,
  output logic [CNT_W-1:0] f_meas_o,
  output logic             accept_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(COARSE_MAX);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(COARSE_MAX + 1);

  logic [CNT_W-1:0] ff_cnt_q, hi_cnt_q;
  logic [31:0]      f32, h32, h_scaled, f_lim_h, f_scaled, h_lim_f;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_cnt_q <= SAT;
      hi_cnt_q <= SAT;
    end else if (fall_i) begin
      ff_cnt_q <= CNT_W'(1);
      hi_cnt_q <= '0;
    end else begin
      if (ff_cnt_q < SAT)           ff_cnt_q <= ff_cnt_q + 1'b1;
      if (line_i && hi_cnt_q < SAT) hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  // cross-multiplied ratio window, no divider needed
  assign f32      = 32'(ff_cnt_q);
  assign h32      = 32'(hi_cnt_q);
  assign h_scaled = h32 * 32'(SIG_FALL_BITS * TOL_DEN);
  assign f_lim_h  = f32 * 32'(SIG_HIGH_BITS * TOL_NUM);
  assign f_scaled = f32 * 32'(SIG_HIGH_BITS * TOL_DEN);
  assign h_lim_f  = h32 * 32'(SIG_FALL_BITS * TOL_NUM);

  assign f_meas_o = ff_cnt_q;
  assign accept_o = fall_i && (ff_cnt_q <= LIM) && (hi_cnt_q <= LIM) &&
                    (hi_cnt_q != '0) && (h_scaled <= f_lim_h) &&
                    (f_scaled <= h_lim_f);
endmodule

// File: rtl/abd_trim_meas.sv
module abd_trim_meas #(
  parameter int TCW     = 19,
  parameter int PERIODS = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           arm_i,
  input  logic           fall_i,
  output logic           cap_v_o,
  output logic [TCW-1:0] cap_o,
  output logic           cap_sat_o
);
  localparam int NFW = $clog2(PERIODS + 1);

  typedef enum logic [1:0] {T_IDLE, T_ARMED, T_RUN} tstate_e;

  tstate_e        st_q;
  logic [TCW-1:0] cnt_q;
  logic [NFW-1:0] nfall_q;
  logic           last_fall;

  assign last_fall = (nfall_q == NFW'(PERIODS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= T_IDLE;
      cnt_q   <= '0;
      nfall_q <= '0;
    end else if (arm_i) begin
      st_q <= T_ARMED;
    end else begin
      case (st_q)
        T_ARMED: if (fall_i) begin
          st_q    <= T_RUN;
          cnt_q   <= TCW'(1);
          nfall_q <= '0;
        end
        T_RUN: begin
          if (!(&cnt_q)) cnt_q <= cnt_q + 1'b1;
          if (fall_i) begin
            if (last_fall) st_q <= T_IDLE;
            else           nfall_q <= nfall_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cap_v_o   = (st_q == T_RUN) && fall_i && last_fall && !arm_i;
  assign cap_o     = cnt_q;
  assign cap_sat_o = &cnt_q;

  // R6: one capture per arming
  a_r6_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_v_o |=> !cap_v_o);
endmodule

// File: rtl/abd_ctrl.sv
module abd_ctrl
  import abd_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int TCW      = 19,
  parameter int TRIM_MIN = 30
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             relock_i,
  input  logic             byte_stb_i,
  input  logic             fall_i,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] f_meas_i,
  input  logic             cap_v_i,
  input  logic [TCW-1:0]   cap_i,
  input  logic             cap_sat_i,
  output logic             arm_o,
  output bit_per_t         bit_per_o,
  output logic             locked_o,
  output logic             rx_en_o
);
  localparam int NCW = CNT_W + FRAC_W;
  localparam int NTW = TCW + FRAC_W;

  phase_e      phase_q;
  logic        pad_cnt_q;
  bit_per_t    bit_per_q, coarse_per, trim_per;
  logic        locked_q, rx_en_q, pad_last, trim_ok;
  logic [NCW-1:0] num_c;
  logic [NTW-1:0] num_t;

  assign num_c      = {f_meas_i, {FRAC_W{1'b0}}};
  assign num_t      = {cap_i, {FRAC_W{1'b0}}};
  assign coarse_per = BP_W'(num_c / NCW'(SIG_FALL_BITS));
  assign trim_per   = BP_W'(num_t / NTW'(TRIM_BITS));
  assign pad_last   = (pad_cnt_q == 1'(PAD_FALLS - 1));
  assign trim_ok    = cap_v_i && !cap_sat_i && (cap_i >= TCW'(TRIM_MIN));

  assign arm_o = !relock_i &&
                 ((phase_q == PH_PAD && fall_i && pad_last) ||
                  (phase_q == PH_TRIM && byte_stb_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_COARSE;
      pad_cnt_q <= 1'b0;
      bit_per_q <= '0;
      locked_q  <= 1'b0;
      rx_en_q   <= 1'b0;
    end else if (relock_i) begin
      phase_q   <= PH_COARSE;
      pad_cnt_q <= 1'b0;
      locked_q  <= 1'b0;
      rx_en_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_COARSE: if (accept_i) begin
          bit_per_q <= coarse_per;
          locked_q  <= 1'b1;
          pad_cnt_q <= 1'b0;
          phase_q   <= PH_PAD;
        end
        PH_PAD: if (fall_i) begin
          if (pad_last) begin
            rx_en_q <= 1'b1;
            phase_q <= PH_TRIM;
          end else begin
            pad_cnt_q <= 1'b1;
          end
        end
        PH_TRIM: if (trim_ok) bit_per_q <= trim_per;
        default: phase_q <= PH_COARSE;
      endcase
    end
  end

  assign bit_per_o = bit_per_q;
  assign locked_o  = locked_q;
  assign rx_en_o   = rx_en_q;

  // R10: period only moves in the cycle after a detected falling edge
  a_r10_update_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bit_per_q) |-> $past(fall_i));
  // R4: lock only follows an accepted candidate
  a_r4_lock_from_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(accept_i));
  // R5: receiver enable implies lock, and rises on a pad edge
  a_r5_en_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_q |-> locked_q);
  a_r5_en_on_pad_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_q) |-> $past(fall_i && phase_q == PH_PAD));
  // R8: short captures leave the period alone
  a_r8_short_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_TRIM && cap_v_i && cap_i < TCW'(TRIM_MIN) && !relock_i)
      |=> $stable(bit_per_q));
  // R9: relock clears lock and enable
  a_r9_relock_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_i |=> (!locked_q && !rx_en_q));
endmodule

// File: rtl/autobaud_trim.sv
module autobaud_trim
  import abd_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int COARSE_MAX  = 60000,
  parameter int TRIM_MIN    = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rx_i,
  input  logic        byte_stb_i,
  input  logic        relock_i,
  output logic [31:0] bit_per_o,
  output logic        locked_o,
  output logic        rx_en_o
);
  localparam int TCW = CNT_W + $clog2(TRIM_BITS);

  logic             line, fall, accept, arm, cap_v, cap_sat;
  logic [CNT_W-1:0] f_meas;
  logic [TCW-1:0]   cap;

  abd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
    .line_o(line), .fall_o(fall)
  );

  abd_coarse_meas #(.CNT_W(CNT_W), .COARSE_MAX(COARSE_MAX)) u_coarse (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line), .fall_i(fall),
    .f_meas_o(f_meas), .accept_o(accept)
  );

  abd_trim_meas #(.TCW(TCW), .PERIODS(TRIM_PERIODS)) u_trim (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(arm), .fall_i(fall),
    .cap_v_o(cap_v), .cap_o(cap), .cap_sat_o(cap_sat)
  );

  abd_ctrl #(.CNT_W(CNT_W), .TCW(TCW), .TRIM_MIN(TRIM_MIN)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .relock_i(relock_i),
    .byte_stb_i(byte_stb_i), .fall_i(fall), .accept_i(accept),
    .f_meas_i(f_meas), .cap_v_i(cap_v), .cap_i(cap), .cap_sat_i(cap_sat),
    .arm_o(arm), .bit_per_o(bit_per_o), .locked_o(locked_o),
    .rx_en_o(rx_en_o)
  );
endmodule

// File: tb/tb_autobaud_trim.sv
`timescale 1ns/1ps
module tb_autobaud_trim;
  localparam int GAP = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic        byte_stb = 1'b0;
  logic        relock = 1'b0;
  logic [31:0] bit_per;
  logic        locked, rx_en;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] last_per = '0;

  always #2.5 clk = ~clk;

  autobaud_trim #(.COARSE_MAX(4000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .byte_stb_i(byte_stb),
    .relock_i(relock), .bit_per_o(bit_per), .locked_o(locked),
    .rx_en_o(rx_en)
  );

  task automatic check(input bit ok, input string req,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expect_per(input logic [31:0] v, input string req);
    exp_q.push_back(v);
    tag_q.push_back(req);
  endtask

  // monitor: every change of the period must match the next queued item
  always @(negedge clk) begin
    if (rst_n && bit_per !== last_per) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected period change", longint'(bit_per),
              longint'(last_per));
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bit_per === e, t, longint'(bit_per), longint'(e));
      end
      last_per = bit_per;
    end
  end

  function automatic int edge_at(input int i, input int px2);
    return (i * px2) / 2;
  endfunction

  function automatic logic [31:0] lock_val(input int px2);
    longint f;
    f = longint'(edge_at(7, px2) - edge_at(0, px2));
    return 32'((f << 16) / 7);
  endfunction

  function automatic logic [31:0] trim_val(input int px2);
    longint c;
    c = longint'(edge_at(8, px2) - edge_at(0, px2));
    return 32'(c << 13);
  endfunction

  // frame: index 0 start, 1..8 data LSB first, 9 stop; called at a negedge
  task automatic send_frame(input logic [7:0] d, input int px2,
                            input bit stb, input int watch);
    logic [9:0] fr;
    fr = {1'b1, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      int len;
      len = edge_at(i + 1, px2) - edge_at(i, px2);
      rx = fr[i];
      for (int c = 1; c <= len; c++) begin
        @(negedge clk);
        byte_stb = stb && (i == 9) && (c == len / 2);
        if (i == watch && c == 2)
          check(rx_en == 1'b0, "R10 enable not before third edge",
                longint'(rx_en), 0);
        if (i == watch && c == 3)
          check(rx_en == 1'b1, "R5 enable on pad second fall",
                longint'(rx_en), 1);
      end
    end
    byte_stb = 1'b0;
    rx = 1'b1;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(locked == 1'b0, "R1 locked after reset", longint'(locked), 0);
    check(rx_en == 1'b0, "R1 rx_en after reset", longint'(rx_en), 0);
    check(bit_per == 32'd0, "R1 period after reset", longint'(bit_per), 0);

    // R2: wrong signatures rejected
    send_frame(8'h55, 74, 1'b0, -1);
    check(locked == 1'b0, "R2 0x55 rejected", longint'(locked), 0);
    send_frame(8'h20, 74, 1'b0, -1);
    check(locked == 1'b0, "R2 0x20 rejected", longint'(locked), 0);

    // R3: correct shape but too slow
    send_frame(8'h3E, 1200, 1'b0, -1);
    check(locked == 1'b0, "R3 over limit rejected", longint'(locked), 0);

    // R4: lock at 37 clocks per bit
    expect_per(lock_val(74), "R4 coarse period");
    send_frame(8'h3E, 74, 1'b0, -1);
    check(locked == 1'b1, "R4 locked", longint'(locked), 1);
    check(rx_en == 1'b0, "R5 rx_en low before pad", longint'(rx_en), 0);

    // R5: a '>' at another rate as pad is ignored; enable on its second fall (index 7)
    send_frame(8'h3E, 90, 1'b0, 7);
    check(bit_per == lock_val(74), "R5 pad leaves period",
          longint'(bit_per), longint'(lock_val(74)));

    // R6: trims
    expect_per(trim_val(80), "R6 trim 40 clocks");
    send_frame(8'h55, 80, 1'b1, -1);
    check(bit_per == trim_val(80), "R6 trim value", longint'(bit_per),
          longint'(trim_val(80)));

    // R7: non-0x55 ignored
    send_frame(8'hAA, 60, 1'b1, -1);
    check(bit_per == trim_val(80), "R7 0xAA ignored", longint'(bit_per),
          longint'(trim_val(80)));

    // R8: capture of 24 clocks dropped
    send_frame(8'h55, 6, 1'b1, -1);
    check(bit_per == trim_val(80), "R8 short capture dropped",
          longint'(bit_per), longint'(trim_val(80)));

    expect_per(trim_val(75), "R6 fractional trim");
    send_frame(8'h55, 75, 1'b1, -1);
    check(bit_per == trim_val(75), "R6 fractional value", longint'(bit_per),
          longint'(trim_val(75)));

    // R9: relock
    relock = 1'b1;
    @(negedge clk);
    relock = 1'b0;
    check(locked == 1'b0, "R9 lock cleared", longint'(locked), 0);
    check(rx_en == 1'b0, "R9 enable cleared", longint'(rx_en), 0);
    check(bit_per == trim_val(75), "R9 period held", longint'(bit_per),
          longint'(trim_val(75)));
    repeat (GAP) @(negedge clk);

    // R4: second lock with a fractional period
    expect_per(lock_val(75), "R4 fractional coarse period");
    send_frame(8'h3E, 75, 1'b0, -1);
    check(locked == 1'b1, "R4 relocked", longint'(locked), 1);

    check(exp_q.size() == 0, "R6 all expected updates seen",
          longint'(exp_q.size()), 0);
    done = 1'b1;
    report();
  end
endmodule